// File: doc/BRIEF.md
# Floppy Command and Result Sequencer

This block carries out the command, execution and result phases of a PC-style floppy disk controller, seen from an 8-bit register window with three address bits. Software enables the controller through the digital output register, then writes an opcode and its parameter bytes, one at a time, to the data port. Read-data and write-data commands take eight parameter bytes. Format-track takes five.

In the execution phase the block holds a single-byte DMA request. For read and write it does not model the sector contents. It keeps the request up until an acknowledge arrives together with terminal count. For format it pulls four ID bytes per sector (cylinder, head, sector, size code) until the programmed sector count is reached or terminal count ends the transfer early. At the end it raises its interrupt. Software then reads a fixed seven-byte result from the data port, and the first of those reads clears the interrupt.

An unrecognised opcode skips the execution phase and leaves one result byte.

Top module: `fdc_sequencer`

## Requirements
- R1: After reset, irq and dma_req are 0, motor_on is 0, ctrl_en is 0, and reads of the data port (offset 5) and of the output register (offset 2) return 0x00.
- R2: A write to offset 2 stores the byte. Bits 7:4 drive motor_on, bit 2 drives ctrl_en, and a read of offset 2 returns the stored byte. Writing 0x1C gives motor_on = 4'b0001 and ctrl_en = 1.
- R3: While ctrl_en is 0, writes to the data port are ignored. A write to offset 2 with bit 2 clear aborts any command in progress: dma_req and irq go to 0 and the sequencer returns to waiting for an opcode.
- R4: Only the opcode's low five bits select the command: 0x06 is read data (8 parameters), 0x05 is write data (8 parameters) and 0x0D is format (5 parameters). Bits 7:5 have no effect, so 0xC6, 0xC5, 0xE5 and 0x4D are all accepted.
- R5: For read and write, dma_req is high from the cycle after the last parameter write. An acknowledge without terminal count does not end the transfer.
- R6: Format parameters are, in order: select, N, SC, GPL, fill byte. Acknowledged DMA bytes are taken as cylinder, head, sector, N, repeating per sector. dma_req drops after 4*SC acknowledges. SC = 0 goes straight to the result phase with no DMA.
- R7: An acknowledge together with dma_tc ends any DMA execution on that cycle, including in the middle of a format sector.
- R8: irq rises in the cycle after execution ends and is never high while dma_req is high. The first read of the data port in the result phase clears irq.
- R9: The seven result bytes are ST0 = select & 0x07 (head in bit 2, drive in bits 1:0), ST1 = 0, ST2 = 0, then C, H, R, N. For read and write, C, H, R and N are parameters 2 to 5. For format, each is the most recently received ID byte of that position, or 0 if none has arrived.
- R10: After the last result byte has been read, the sequencer waits for a new opcode. A data-port read with no result pending returns 0x00.
- R11: An unrecognised opcode produces a single result byte of 0x80, with no DMA request and no interrupt.
- R12: Data-port writes during the execution or result phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 3 | Register offset |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| motor_on | output | 4 | Motor enables from the output register |
| ctrl_en | output | 1 | Controller enabled (output register bit 2) |
| dma_req | output | 1 | DMA byte request |
| dma_ack | input | 1 | DMA byte acknowledge, one byte per high cycle |
| dma_tc | input | 1 | Terminal count, meaningful with dma_ack |
| dma_rdata | input | 8 | Byte delivered by DMA during format |
| irq | output | 1 | Interrupt, end of execution |

## Verification
The hardest state to reach is a format ended by terminal count partway through a sector. Here the echoed C and H come from the cut-off sector, while R and N are still left over from the sector before it. The bench reaches this state by programming three sectors and raising dma_tc on the sixth acknowledge. It then checks that dma_req drops at once and that the mixed ID shows up in the result. An abort mid-format, caused by clearing the enable bit, is also driven while DMA is pending. A data-port write is injected during the execution phase and another during the result phase, to show that neither disturbs the sequence.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PARAM,
    S_XFER,
    S_FMT,
    S_RESULT
  } seq_state_t;

  typedef enum logic [1:0] {
    K_READ,
    K_WRITE,
    K_FORMAT
  } cmd_kind_t;

  localparam logic [4:0] OPC_READ   = 5'h06;
  localparam logic [4:0] OPC_WRITE  = 5'h05;
  localparam logic [4:0] OPC_FORMAT = 5'h0D;
  localparam logic [7:0] RES_INVALID = 8'h80;
endpackage

// File: rtl/fdc_dor_reg.sv
module fdc_dor_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/fdc_param_bank.sv
module fdc_param_bank #(
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  localparam int IDX_W     = $clog2(MAX_PARAMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  input  logic [IDX_W-1:0]  ridx_b,
  input  logic [IDX_W-1:0]  ridx_c,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] rdata_c
);
  logic [DATA_W-1:0] slot [MAX_PARAMS];

  for (genvar g = 0; g < MAX_PARAMS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot[g] <= '0;
      else if (we && widx == IDX_W'(g)) slot[g] <= wdata;
    end
  end

  assign rdata_a = slot[ridx_a];
  assign rdata_b = slot[ridx_b];
  assign rdata_c = slot[ridx_c];
endmodule

// File: rtl/fdc_id_latch.sv
module fdc_id_latch #(
  parameter int DATA_W   = 8,
  parameter int ID_BYTES = 4,
  localparam int ID_W    = $clog2(ID_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [ID_W-1:0]   widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ID_W-1:0]   ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] id_q [ID_BYTES];

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    always_ff @(posedge clk) begin
      if (!rst_n || clr) id_q[g] <= '0;
      else if (we && widx == ID_W'(g)) id_q[g] <= wdata;
    end
  end

  assign rdata = id_q[ridx];
endmodule

// File: rtl/fdc_sequencer.sv
module fdc_sequencer
  import fdc_seq_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int MAX_PARAMS = 8,
  parameter int FMT_PARAMS = 5,
  parameter int RESULT_LEN = 7,
  parameter int ID_BYTES   = 4,
  parameter int DATA_PORT  = 5,
  parameter int DOR_PORT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [3:0]        motor_on,
  output logic              ctrl_en,
  output logic              dma_req,
  input  logic              dma_ack,
  input  logic              dma_tc,
  input  logic [DATA_W-1:0] dma_rdata,
  output logic              irq
);
  localparam int PIDX_W = $clog2(MAX_PARAMS);
  localparam int RIDX_W = $clog2(RESULT_LEN);
  localparam int ID_W   = $clog2(ID_BYTES);
  localparam int EN_BIT = 2;
  localparam logic [DATA_W-1:0] DS_MASK = DATA_W'(8'h07);
  localparam logic [PIDX_W-1:0] RW_LAST  = PIDX_W'(MAX_PARAMS - 1);
  localparam logic [PIDX_W-1:0] FMT_LAST = PIDX_W'(FMT_PARAMS - 1);
  localparam logic [PIDX_W-1:0] SEL_IDX  = '0;
  localparam logic [PIDX_W-1:0] SC_IDX   = PIDX_W'(2);
  localparam logic [RIDX_W-1:0] RES_LAST = RIDX_W'(RESULT_LEN - 1);
  localparam logic [RIDX_W-1:0] CHRN_BASE = RIDX_W'(3);
  localparam logic [ID_W-1:0]   ID_LAST  = ID_W'(ID_BYTES - 1);

  seq_state_t        state;
  cmd_kind_t         kind;
  logic [PIDX_W-1:0] pcnt, plast;
  logic [RIDX_W-1:0] ridx, rlast;
  logic [ID_W-1:0]   bcnt;
  logic [DATA_W-1:0] sec_cnt, sec_next;
  logic              bad_cmd;

  logic [DATA_W-1:0] dor_q, sel_byte, sc_byte, par_byte, id_byte, res_byte;
  logic              data_wr, data_rd, dor_wr, abort, opc_ok, fmt_end;
  cmd_kind_t         opc_kind;

  // Register window decode
  assign dor_wr  = io_wr && io_addr == ADDR_W'(DOR_PORT);
  assign data_wr = io_wr && io_addr == ADDR_W'(DATA_PORT) && ctrl_en;
  assign data_rd = io_rd && io_addr == ADDR_W'(DATA_PORT);
  assign abort   = !ctrl_en || (dor_wr && !io_wdata[EN_BIT]);

  fdc_dor_reg #(.DATA_W(DATA_W)) u_dor (
    .clk(clk), .rst_n(rst_n), .we(dor_wr), .wdata(io_wdata), .value(dor_q)
  );
  assign motor_on = dor_q[7:4];
  assign ctrl_en  = dor_q[EN_BIT];

  // Opcode decode: low five bits only
  always_comb begin
    opc_ok   = 1'b1;
    opc_kind = K_READ;
    unique case (io_wdata[4:0])
      OPC_READ:   opc_kind = K_READ;
      OPC_WRITE:  opc_kind = K_WRITE;
      OPC_FORMAT: opc_kind = K_FORMAT;
      default:    opc_ok   = 1'b0;
    endcase
  end

  fdc_param_bank #(.DATA_W(DATA_W), .MAX_PARAMS(MAX_PARAMS)) u_params (
    .clk(clk), .rst_n(rst_n),
    .we(state == S_PARAM && data_wr && !abort),
    .widx(pcnt), .wdata(io_wdata),
    .ridx_a(SEL_IDX), .ridx_b(SC_IDX),
    .ridx_c(PIDX_W'(ridx) - PIDX_W'(2)),
    .rdata_a(sel_byte), .rdata_b(sc_byte), .rdata_c(par_byte)
  );

  fdc_id_latch #(.DATA_W(DATA_W), .ID_BYTES(ID_BYTES)) u_ids (
    .clk(clk), .rst_n(rst_n),
    .clr(state == S_IDLE && data_wr),
    .we(state == S_FMT && dma_ack && !abort),
    .widx(bcnt), .wdata(dma_rdata),
    .ridx(ID_W'(ridx - CHRN_BASE)),
    .rdata(id_byte)
  );

  assign sec_next = sec_cnt + 1'b1;
  assign fmt_end  = dma_tc || (bcnt == ID_LAST && sec_next == sc_byte);
  assign dma_req  = (state == S_XFER) || (state == S_FMT);

  // Phase sequencer
  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      state   <= S_IDLE;
      kind    <= K_READ;
      pcnt    <= '0;
      plast   <= '0;
      ridx    <= '0;
      rlast   <= '0;
      bcnt    <= '0;
      sec_cnt <= '0;
      bad_cmd <= 1'b0;
      irq     <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (data_wr) begin
          pcnt <= '0;
          ridx <= '0;
          if (opc_ok) begin
            kind    <= opc_kind;
            plast   <= (opc_kind == K_FORMAT) ? FMT_LAST : RW_LAST;
            bad_cmd <= 1'b0;
            state   <= S_PARAM;
          end else begin
            bad_cmd <= 1'b1;
            rlast   <= '0;
            state   <= S_RESULT;
          end
        end
        S_PARAM: if (data_wr) begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == plast) begin
            bcnt    <= '0;
            sec_cnt <= '0;
            rlast   <= RES_LAST;
            if (kind != K_FORMAT) begin
              state <= S_XFER;
            end else if (sc_byte == '0) begin
              state <= S_RESULT;
              irq   <= 1'b1;
            end else begin
              state <= S_FMT;
            end
          end
        end
        S_XFER: if (dma_ack && dma_tc) begin
          state <= S_RESULT;
          irq   <= 1'b1;
        end
        S_FMT: if (dma_ack) begin
          if (fmt_end) begin
            state <= S_RESULT;
            irq   <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == ID_LAST) sec_cnt <= sec_next;
          end
        end
        S_RESULT: if (data_rd) begin
          irq <= 1'b0;
          if (ridx == rlast) begin
            state   <= S_IDLE;
            bad_cmd <= 1'b0;
          end else begin
            ridx <= ridx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Result byte selection
  always_comb begin
    if (bad_cmd) res_byte = RES_INVALID;
    else if (ridx == '0) res_byte = sel_byte & DS_MASK;
    else if (ridx < CHRN_BASE) res_byte = '0;
    else if (kind == K_FORMAT) res_byte = id_byte;
    else res_byte = par_byte;
  end

  always_comb begin
    io_rdata = '0;
    if (io_addr == ADDR_W'(DOR_PORT)) io_rdata = dor_q;
    else if (io_addr == ADDR_W'(DATA_PORT) && state == S_RESULT) io_rdata = res_byte;
  end
endmodule

// File: rtl/fdc_sequencer_checker.sv
module fdc_sequencer_checker #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int DATA_PORT = 5,
  parameter int DOR_PORT  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [DATA_W-1:0] io_wdata,
  input logic [3:0]        motor_on,
  input logic              ctrl_en,
  input logic              dma_req,
  input logic              dma_ack,
  input logic              dma_tc,
  input logic              irq
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (!dma_req && !irq)); // R3

  AST_REQ_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && irq)); // R8

  AST_TC_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && dma_tc && !io_wr) |=> (!dma_req && irq)); // R7

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && io_rd && !io_wr && io_addr == ADDR_W'(DATA_PORT)) |=> !irq); // R8

  AST_MOTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == ADDR_W'(DOR_PORT)) |=> motor_on == $past(io_wdata[7:4])); // R2
endmodule

bind fdc_sequencer fdc_sequencer_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_PORT(DATA_PORT), .DOR_PORT(DOR_PORT)
) u_fdc_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .motor_on(motor_on), .ctrl_en(ctrl_en),
  .dma_req(dma_req), .dma_ack(dma_ack), .dma_tc(dma_tc), .irq(irq)
);

// File: tb/fdc_sequencer_bench.sv
`timescale 1ns/1ps
module fdc_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] io_addr = '0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic [3:0] motor_on;
  logic       ctrl_en, dma_req, irq;
  logic       dma_ack = 1'b0, dma_tc = 1'b0;
  logic [7:0] dma_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fdc_sequencer u_fdc_sequencer (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .motor_on(motor_on), .ctrl_en(ctrl_en),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_rdata(dma_rdata),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 check(tag, io_rdata, exp);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic dma_byte(input logic [7:0] d, input logic tc);
    @(negedge clk);
    dma_ack = 1'b1; dma_tc = tc; dma_rdata = d;
    @(negedge clk);
    dma_ack = 1'b0; dma_tc = 1'b0;
  endtask

  task automatic read_results(input logic [7:0] exp [7], input string tag);
    for (int i = 0; i < 7; i++) begin
      rd_check(3'd5, exp[i], $sformatf("%s R9 byte%0d", tag, i));
      if (i == 0) check({tag, " R8 irq cleared by first read"}, {7'b0, irq}, 8'h00);
    end
    rd_check(3'd5, 8'h00, {tag, " R10 idle after seventh byte"});
  endtask

  task automatic t_reset();
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 dma_req", {7'b0, dma_req}, 8'h00);
    check("R1 motor_on", {4'b0, motor_on}, 8'h00);
    check("R1 ctrl_en", {7'b0, ctrl_en}, 8'h00);
    rd_check(3'd5, 8'h00, "R1 data port");
    rd_check(3'd2, 8'h00, "R1 output register");
  endtask

  task automatic t_disabled_writes();
    wr(3'd5, 8'hC6);
    for (int i = 0; i < 8; i++) wr(3'd5, 8'h11);
    check("R3 disabled data writes ignored", {7'b0, dma_req}, 8'h00);
  endtask

  task automatic t_enable();
    wr(3'd2, 8'h1C);
    check("R2 motor_on", {4'b0, motor_on}, 8'h01);
    check("R2 ctrl_en", {7'b0, ctrl_en}, 8'h01);
    rd_check(3'd2, 8'h1C, "R2 readback");
  endtask

  task automatic t_read_cmd();
    logic [7:0] p [8] = '{8'h04, 8'h12, 8'h01, 8'h05, 8'h02, 8'h08, 8'hFF, 8'hFF};
    logic [7:0] e [7] = '{8'h04, 8'h00, 8'h00, 8'h12, 8'h01, 8'h05, 8'h02};
    wr(3'd5, 8'hC6);
    for (int i = 0; i < 8; i++) begin
      check("R5 no req during params", {7'b0, dma_req}, 8'h00);
      wr(3'd5, p[i]);
    end
    check("R5 req after last param", {7'b0, dma_req}, 8'h01);
    for (int i = 0; i < 3; i++) dma_byte(8'h00, 1'b0);
    check("R5 ack without tc keeps req", {7'b0, dma_req}, 8'h01);
    check("R8 no irq during exec", {7'b0, irq}, 8'h00);
    dma_byte(8'h00, 1'b1);
    check("R7 tc drops req", {7'b0, dma_req}, 8'h00);
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    read_results(e, "read");
  endtask

  task automatic t_write_cmd();
    logic [7:0] p [8] = '{8'h05, 8'h20, 8'h00, 8'h03, 8'h02, 8'h09, 8'h1B, 8'hFF};
    logic [7:0] e [7] = '{8'h05, 8'h00, 8'h00, 8'h20, 8'h00, 8'h03, 8'h02};
    wr(3'd5, 8'hE5);
    for (int i = 0; i < 8; i++) wr(3'd5, p[i]);
    check("R4 0xE5 accepted as write", {7'b0, dma_req}, 8'h01);
    dma_byte(8'h00, 1'b1);
    check("R7 tc on first ack", {7'b0, irq}, 8'h01);
    read_results(e, "write");
  endtask

  task automatic t_format_full();
    logic [7:0] ids [8] = '{8'h1E, 8'h01, 8'h0C, 8'h02, 8'h1E, 8'h01, 8'h0D, 8'h02};
    logic [7:0] e [7] = '{8'h00, 8'h00, 8'h00, 8'h1E, 8'h01, 8'h0D, 8'h02};
    wr(3'd5, 8'h4D);
    wr(3'd5, 8'h00); wr(3'd5, 8'h02); wr(3'd5, 8'h02); wr(3'd5, 8'hFF);
    check("R6 no req before last format param", {7'b0, dma_req}, 8'h00);
    wr(3'd5, 8'hAB);
    check("R4 0x4D starts format", {7'b0, dma_req}, 8'h01);
    for (int i = 0; i < 8; i++) begin
      if (i == 4) wr(3'd5, 8'h13);
      dma_byte(ids[i], 1'b0);
      if (i < 7) check("R6 req held within SC sectors", {7'b0, dma_req}, 8'h01);
    end
    check("R6 req drops after 4*SC", {7'b0, dma_req}, 8'h00);
    check("R8 format irq", {7'b0, irq}, 8'h01);
    wr(3'd5, 8'h4D);
    read_results(e, "format R12");
  endtask

  task automatic t_format_tc();
    logic [7:0] ids [6] = '{8'h1F, 8'h00, 8'h01, 8'h02, 8'h20, 8'h01};
    logic [7:0] e [7] = '{8'h01, 8'h00, 8'h00, 8'h20, 8'h01, 8'h01, 8'h02};
    wr(3'd5, 8'h4D);
    wr(3'd5, 8'h01); wr(3'd5, 8'h02); wr(3'd5, 8'h03); wr(3'd5, 8'hFF); wr(3'd5, 8'hF6);
    for (int i = 0; i < 6; i++) dma_byte(ids[i], i == 5);
    check("R7 mid-sector tc drops req", {7'b0, dma_req}, 8'h00);
    check("R7 mid-sector tc irq", {7'b0, irq}, 8'h01);
    read_results(e, "format-tc");
  endtask

  task automatic t_format_sc0();
    logic [7:0] e [7] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr(3'd5, 8'h4D);
    wr(3'd5, 8'h00); wr(3'd5, 8'h02); wr(3'd5, 8'h00); wr(3'd5, 8'hFF); wr(3'd5, 8'hAB);
    check("R6 SC=0 no req", {7'b0, dma_req}, 8'h00);
    check("R6 SC=0 irq", {7'b0, irq}, 8'h01);
    read_results(e, "format-sc0");
  endtask

  task automatic t_invalid();
    wr(3'd5, 8'h1F);
    check("R11 no irq", {7'b0, irq}, 8'h00);
    check("R11 no req", {7'b0, dma_req}, 8'h00);
    rd_check(3'd5, 8'h80, "R11 invalid result");
    rd_check(3'd5, 8'h00, "R11 single byte then R10 idle");
  endtask

  task automatic t_abort();
    wr(3'd5, 8'h4D);
    wr(3'd5, 8'h00); wr(3'd5, 8'h02); wr(3'd5, 8'h04); wr(3'd5, 8'hFF); wr(3'd5, 8'hAB);
    dma_byte(8'h30, 1'b0);
    dma_byte(8'h01, 1'b0);
    wr(3'd2, 8'h10);
    check("R3 abort drops req", {7'b0, dma_req}, 8'h00);
    check("R3 abort irq low", {7'b0, irq}, 8'h00);
    check("R3 ctrl_en low", {7'b0, ctrl_en}, 8'h00);
    rd_check(3'd5, 8'h00, "R3 no result after abort");
    wr(3'd2, 8'h1C);
    wr(3'd5, 8'h1F);
    rd_check(3'd5, 8'h80, "R3 back to opcode wait");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled_writes();
    t_enable();
    t_read_cmd();
    t_write_cmd();
    t_format_full();
    t_format_tc();
    t_format_sc0();
    t_invalid();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule